// File: doc/BRIEF.md
# Double-Pumped Pixel Input Capture

This block receives a 12-bit pixel bus that carries two words per clock period, one per clock edge, and rebuilds full 24-bit RGB pixels. In dual mode a second 12-bit port, on the upper half of the data input, is rebuilt in the same way into a second pixel. The pixels and the normalized data-enable and sync signals leave the block from registers clocked on the rising edge of the single input clock.

A mode input picks which clock edge is primary. The primary-edge word holds the low half of the pixel: blue and the low green nibble. The secondary-edge word holds red and the high green nibble. Data enable is sampled on the secondary edge and the two syncs on the primary edge. The active level of the incoming data enable is selectable, and each sync can be forced low.

Top module: `dpc_pixel_capture`

## Requirements
- R1: The primary-edge word is the low half. Its bits 11..8 become G[3:0] and its bits 7..0 become B[7:0]. Each pixel output is packed as {R[7:0], G[7:0], B[7:0]}, with R in bits 23..16.
- R2: The secondary-edge word is the high half. Its bits 11..4 become R[7:0] and its bits 3..0 become G[7:4].
- R3: With `edge_fall_i` low, the primary edge is rising. The low word sampled at rising edge k-1 and the high word sampled at the following falling edge appear on the pixel outputs just after rising edge k.
- R4: With `edge_fall_i` high, the primary edge is falling. The low word sampled at the falling edge before rising edge k and the high word sampled at rising edge k appear on the pixel outputs just after rising edge k.
- R5: `de_i` is sampled on the secondary edge. `hsync_i` and `vsync_i` are sampled on the primary edge. All three reach the outputs together with the pixel whose words they accompany.
- R6: With `dual_i` high, bits 11..0 of `din_i` carry the odd pixel and bits 23..12 carry the even pixel, each with the R1/R2 mapping. With `dual_i` low, `pix_even_o` is zero and bits 23..12 have no effect.
- R7: With `de_act_hi_i` high, `de_o` equals the sampled DE. With it low, `de_o` is the inverse of the sampled DE.
- R8: With `hs_en_i` low, `hsync_o` is 0. With `vs_en_i` low, `vsync_o` is 0. With an enable high, the sampled sync passes through unchanged.
- R9: A synchronous active-high `rst` clears both pixel outputs and drives `de_o`, `hsync_o` and `vsync_o` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges sample input data |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | 24 | Two 12-bit half-word ports (odd port in 11..0) |
| de_i | input | 1 | Data enable, active level set by de_act_hi_i |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| edge_fall_i | input | 1 | 1: falling edge primary; 0: rising edge primary |
| de_act_hi_i | input | 1 | 1: DE active high; 0: DE active low |
| hs_en_i | input | 1 | Horizontal sync pass enable |
| vs_en_i | input | 1 | Vertical sync pass enable |
| dual_i | input | 1 | 1: two ports active; 0: odd port only |
| pix_odd_o | output | 24 | Rebuilt odd pixel {R,G,B} |
| pix_even_o | output | 24 | Rebuilt even pixel {R,G,B} (zero in single mode) |
| de_o | output | 1 | Normalized data enable, active high |
| hsync_o | output | 1 | Gated horizontal sync |
| vsync_o | output | 1 | Gated vertical sync |

## Verification
On every cycle, the assertions check where the blue byte comes from in the rising-primary mode, where the high word comes from in the falling-primary mode, that the even pixel stays zero in single mode, and that a disabled sync stays low. Only the bench scenarios can show that the whole colour mapping is right for both edge choices. They also show that DE and the syncs come from opposite edges: the bench drives opposite values on the wrong edge. The remaining scenario-only behaviours are the DE polarity inversion and the clearing by reset.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int COLOR_W = 8;
  localparam int HALF_W  = 12;
  localparam int PIX_W   = 3 * COLOR_W;
  localparam int GLO_W   = HALF_W - COLOR_W;       // green bits carried by the low word
  localparam int GHI_W   = COLOR_W - GLO_W;        // green bits carried by the high word

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } rgb_t;

  function automatic rgb_t join_halves(input logic [HALF_W-1:0] lo,
                                       input logic [HALF_W-1:0] hi);
    rgb_t p;
    p.b = lo[COLOR_W-1:0];
    p.g = {hi[GHI_W-1:0], lo[HALF_W-1:COLOR_W]};
    p.r = hi[HALF_W-1:GHI_W];
    return p;
  endfunction
endpackage

// File: rtl/dpc_edge_pair.sv
module dpc_edge_pair #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);
  always_ff @(posedge clk) begin
    if (rst) rise_q <= '0;
    else     rise_q <= d_i;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= d_i;
  end
endmodule

// File: rtl/dpc_half_join.sv
module dpc_half_join
  import dpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              edge_fall_i,
  input  logic [HALF_W-1:0] rise_w_i,
  input  logic [HALF_W-1:0] fall_w_i,
  input  logic [HALF_W-1:0] now_w_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [HALF_W-1:0] lo_w, hi_w;
  rgb_t              joined;
  logic              past_ok;

  always_comb begin
    if (edge_fall_i) begin
      lo_w = fall_w_i;
      hi_w = now_w_i;
    end else begin
      lo_w = rise_w_i;
      hi_w = fall_w_i;
    end
    joined = join_halves(lo_w, hi_w);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) pix_o <= '0;
    else              pix_o <= joined;
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_BLUE_FROM_RISE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(en_i) && !$past(edge_fall_i)) |-> pix_o[COLOR_W-1:0] == $past(rise_w_i[COLOR_W-1:0])); // R3
  AST_HIGH_FROM_NOW: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(en_i) && $past(edge_fall_i)) |-> pix_o[PIX_W-1:PIX_W-HALF_W] == $past(now_w_i)); // R4
  AST_IDLE_PORT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(en_i)) |-> pix_o == '0); // R6
endmodule

// File: rtl/dpc_ctrl_norm.sv
module dpc_ctrl_norm (
  input  logic clk,
  input  logic rst,
  input  logic edge_fall_i,
  input  logic de_act_hi_i,
  input  logic hs_en_i,
  input  logic vs_en_i,
  input  logic de_i,
  input  logic hsync_i,
  input  logic vsync_i,
  output logic de_o,
  output logic hsync_o,
  output logic vsync_o
);
  localparam int CW = 3;
  logic [CW-1:0] rise_c, fall_c;
  logic          de_raw, hs_raw, vs_raw;
  logic          past_ok;

  dpc_edge_pair #(.W(CW)) ctl_cap_i (
    .clk    (clk),
    .rst    (rst),
    .d_i    ({de_i, hsync_i, vsync_i}),
    .rise_q (rise_c),
    .fall_q (fall_c)
  );

  // DE rides the secondary edge, syncs the primary edge
  always_comb begin
    if (edge_fall_i) begin
      de_raw = de_i;
      hs_raw = fall_c[1];
      vs_raw = fall_c[0];
    end else begin
      de_raw = fall_c[2];
      hs_raw = rise_c[1];
      vs_raw = rise_c[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o    <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      de_o    <= de_act_hi_i ? de_raw : ~de_raw;
      hsync_o <= hs_en_i & hs_raw;
      vsync_o <= vs_en_i & vs_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_HS_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(hs_en_i)) |-> !hsync_o); // R8
  AST_VS_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(vs_en_i)) |-> !vsync_o); // R8
endmodule

// File: rtl/dpc_pixel_capture.sv
module dpc_pixel_capture
  import dpc_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*HALF_W-1:0] din_i,
  input  logic                        de_i,
  input  logic                        hsync_i,
  input  logic                        vsync_i,
  input  logic                        edge_fall_i,
  input  logic                        de_act_hi_i,
  input  logic                        hs_en_i,
  input  logic                        vs_en_i,
  input  logic                        dual_i,
  output logic [PIX_W-1:0]            pix_odd_o,
  output logic [PIX_W-1:0]            pix_even_o,
  output logic                        de_o,
  output logic                        hsync_o,
  output logic                        vsync_o
);
  logic [NUM_PORTS*PIX_W-1:0] pix_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [HALF_W-1:0] rise_w, fall_w;
    logic              port_en;
    assign port_en = (p == 0) ? 1'b1 : dual_i;

    dpc_edge_pair #(.W(HALF_W)) cap_i (
      .clk    (clk),
      .rst    (rst),
      .d_i    (din_i[p*HALF_W +: HALF_W]),
      .rise_q (rise_w),
      .fall_q (fall_w)
    );

    dpc_half_join join_i (
      .clk         (clk),
      .rst         (rst),
      .en_i        (port_en),
      .edge_fall_i (edge_fall_i),
      .rise_w_i    (rise_w),
      .fall_w_i    (fall_w),
      .now_w_i     (din_i[p*HALF_W +: HALF_W]),
      .pix_o       (pix_all[p*PIX_W +: PIX_W])
    );
  end

  assign pix_odd_o  = pix_all[0 +: PIX_W];
  assign pix_even_o = pix_all[PIX_W +: PIX_W];

  dpc_ctrl_norm ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .edge_fall_i (edge_fall_i),
    .de_act_hi_i (de_act_hi_i),
    .hs_en_i     (hs_en_i),
    .vs_en_i     (vs_en_i),
    .de_i        (de_i),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .de_o        (de_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o)
  );
endmodule

// File: tb/dpc_pixel_capture_tb.sv
module dpc_pixel_capture_tb_top;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] din_i;
  logic        de_i, hsync_i, vsync_i;
  logic        edge_fall_i, de_act_hi_i, hs_en_i, vs_en_i, dual_i;
  logic [23:0] pix_odd_o, pix_even_o;
  logic        de_o, hsync_o, vsync_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  dpc_pixel_capture dut_i (
    .clk(clk), .rst(rst), .din_i(din_i), .de_i(de_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .edge_fall_i(edge_fall_i), .de_act_hi_i(de_act_hi_i), .hs_en_i(hs_en_i), .vs_en_i(vs_en_i),
    .dual_i(dual_i), .pix_odd_o(pix_odd_o), .pix_even_o(pix_even_o),
    .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  function automatic logic [23:0] expect_pix(input logic [11:0] lo, input logic [11:0] hi);
    logic [7:0] r, g, b;
    b = lo[7:0];
    g = {hi[3:0], lo[11:8]};
    r = hi[11:4];
    return {r, g, b};
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lo words and syncs go on the primary edge, hi words and DE on the secondary;
  // the other edge carries opposite control values so a wrong-edge sample shows up
  task automatic send(input logic [11:0] lo0, input logic [11:0] hi0,
                      input logic [11:0] lo1, input logic [11:0] hi1,
                      input logic de, input logic hs, input logic vs);
    if (!edge_fall_i) begin
      @(negedge clk); #2;
      din_i = {lo1, lo0}; de_i = ~de; hsync_i = hs; vsync_i = vs;
      @(posedge clk); #2;
      din_i = {hi1, hi0}; de_i = de; hsync_i = ~hs; vsync_i = ~vs;
      @(posedge clk); #1;
    end else begin
      @(posedge clk); #2;
      din_i = {lo1, lo0}; de_i = ~de; hsync_i = hs; vsync_i = vs;
      @(negedge clk); #2;
      din_i = {hi1, hi0}; de_i = de; hsync_i = ~hs; vsync_i = ~vs;
      @(posedge clk); #1;
    end
  endtask

  task automatic check_all(input string tag, input logic [11:0] lo0, input logic [11:0] hi0,
                           input logic [11:0] lo1, input logic [11:0] hi1,
                           input logic de, input logic hs, input logic vs);
    chk({tag, " R1 R2 odd pixel"}, pix_odd_o, expect_pix(lo0, hi0));
    chk({tag, " R6 even pixel"}, pix_even_o, dual_i ? expect_pix(lo1, hi1) : 24'h0);
    chk({tag, " R5 R7 de"}, {23'h0, de_o}, {23'h0, de_act_hi_i ? de : ~de});
    chk({tag, " R5 R8 hsync"}, {23'h0, hsync_o}, {23'h0, hs_en_i & hs});
    chk({tag, " R5 R8 vsync"}, {23'h0, vsync_o}, {23'h0, vs_en_i & vs});
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; din_i = 24'hABCDEF; de_i = 1'b1; hsync_i = 1'b1; vsync_i = 1'b1;
    edge_fall_i = 1'b0; de_act_hi_i = 1'b1; hs_en_i = 1'b1; vs_en_i = 1'b1; dual_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 reset odd", pix_odd_o, 24'h0);
    chk("R9 reset even", pix_even_o, 24'h0);
    chk("R9 reset ctrl", {21'h0, de_o, hsync_o, vsync_o}, 24'h0);
    rst = 1'b0;

    // R1 R2 R3 R4: walking ones through every low and high bit, both edge choices
    for (int f = 0; f < 2; f++) begin
      edge_fall_i = f[0];
      for (int b = 0; b < 12; b++) begin
        logic [11:0] w;
        w = 12'h1 << b;
        send(w, 12'h0, 12'h0, w, 1'b1, 1'b0, 1'b0);
        check_all(f ? "R4 walk lo" : "R3 walk lo", w, 12'h0, 12'h0, w, 1'b1, 1'b0, 1'b0);
        send(12'h0, w, w, 12'h0, 1'b0, 1'b1, 1'b1);
        check_all(f ? "R4 walk hi" : "R3 walk hi", 12'h0, w, w, 12'h0, 1'b0, 1'b1, 1'b1);
      end
    end

    // exhaustive sweep over all mode and control combinations
    for (int c = 0; c < 256; c++) begin
      logic [11:0] l0, h0, l1, h1;
      edge_fall_i = c[0]; dual_i = c[1]; de_act_hi_i = c[2];
      hs_en_i = c[3]; vs_en_i = c[4];
      l0 = 12'((c * 37 + 5) & 12'hFFF);
      h0 = 12'((c * 91 + 1234) & 12'hFFF);
      l1 = 12'((c * 53 + 2900) & 12'hFFF);
      h1 = 12'((c * 17 + 777) & 12'hFFF);
      send(l0, h0, l1, h1, c[5], c[6], c[7]);
      check_all(c[0] ? "R4 sweep" : "R3 sweep", l0, h0, l1, h1, c[5], c[6], c[7]);
    end

    // R9: reset in mid-stream clears outputs at the next rising edge
    edge_fall_i = 1'b0; dual_i = 1'b1; de_act_hi_i = 1'b1; hs_en_i = 1'b1; vs_en_i = 1'b1;
    send(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 1'b1, 1'b1, 1'b1);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 midrun odd", pix_odd_o, 24'h0);
    chk("R9 midrun even", pix_even_o, 24'h0);
    chk("R9 midrun ctrl", {21'h0, de_o, hsync_o, vsync_o}, 24'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule